// File: doc/BRIEF.md
# Spare-Row Remapping Memory

This block is a word-addressed memory that always looks defect-free at a fixed logical size. Its physical storage holds a few more rows than the logical capacity. The extra rows are used only as replacements. A small repair table lists the logical rows that are known to be bad, and each entry is tied to one spare row.

Every access compares its logical row address with all repair entries at once, in the address decode path. On a match, the access goes to the spare row assigned to that entry. On a miss, it goes to the row with the same number. Reads return data one cycle later, and that latency is the same whether or not a substitution happens. Software therefore never sees the bad rows.

The repair table is written before normal operation through a configuration port that models fuse programming. A sticky lock freezes the table. A separate status output flags a part whose reported defect count is larger than the number of spares, because the block never offers a smaller capacity.

Top module: `spare_row_mem`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are 0, every repair entry is invalid, and the block is unlocked.
- R2: An access whose row matches no valid repair entry uses physical row equal to the logical row; `acc_phys_row` shows this in the same cycle the address is presented.
- R3: An access whose row matches valid entry k (k = 0..SPARES-1) uses physical row LOG_ROWS + k.
- R4: A read sets `rd_valid` high for exactly the next cycle. `rd_data` then holds the last value written to that logical row under the same mapping. A cycle with no read leaves `rd_valid` low, with or without substitution.
- R5: A repair-table write (`cfg_wr`) changes the table only while `cfg_prog_en` is high; otherwise the table is unchanged.
- R6: Once `cfg_lock` has been taken while `cfg_prog_en` is high and the block is unlocked, the block stays locked until reset and ignores all later table writes.
- R7: If several valid entries hold the same row, the entry with the lowest index supplies the spare row.
- R8: An entry written with its valid bit (`cfg_vld`) at 0 causes no substitution for its stored row.
- R9: `unrepairable` is high exactly when `defect_cnt` is greater than SPARES (4 by default). It is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prog_en | input | 1 | Programming window enable |
| cfg_wr | input | 1 | Write one repair entry |
| cfg_idx | input | IDX_W (2) | Repair entry index |
| cfg_vld | input | 1 | Valid bit for the entry |
| cfg_row | input | ROW_W (6) | Faulty logical row for the entry |
| cfg_lock | input | 1 | Lock the repair table |
| acc_en | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ROW_W (6) | Logical row address |
| acc_wdata | input | DATA_W (16) | Write data |
| acc_phys_row | output | PHYS_W (7) | Physical row selected by the decoder |
| rd_data | output | DATA_W (16) | Read data, one cycle after the read |
| rd_valid | output | 1 | Read data valid |
| defect_cnt | input | DCNT_W (7) | Defect count reported by external test |
| unrepairable | output | 1 | Defects exceed spares |

## Verification
The bench places duplicate row entries in a higher and a lower slot. A decoder with the wrong priority would send that row to the wrong spare. An invalid entry's row is accessed to catch a design that matches without checking the valid bit. Table writes are attempted both outside the programming window and after locking. A missing gate would move the row to a spare, and this shows up on `acc_phys_row`. Data written through a substituted row is read back to confirm the one-cycle latency holds on the spare path. The defect counts of 4 and 5 pin down an off-by-one in the unrepairable flag.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } acc_op_e;

    function automatic acc_op_e decode_op(input logic en, input logic we);
        if (!en)
            return OP_IDLE;
        return we ? OP_WRITE : OP_READ;
    endfunction
endpackage

// File: rtl/srm_repair_table.sv
module srm_repair_table #(
    parameter int SPARES = 4,
    parameter int ROW_W  = 6,
    parameter int IDX_W  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            prog_en,
    input  logic                            cfg_wr,
    input  logic [IDX_W-1:0]                cfg_idx,
    input  logic                            cfg_vld,
    input  logic [ROW_W-1:0]                cfg_row,
    input  logic                            cfg_lock,
    output logic [SPARES-1:0]               ent_vld,
    output logic [SPARES-1:0][ROW_W-1:0]    ent_row
);
    typedef struct packed {
        logic [SPARES-1:0]            vld;
        logic [SPARES-1:0][ROW_W-1:0] row;
        logic                         lock;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (prog_en && !tbl_q.lock) begin
            if (cfg_wr && (int'(cfg_idx) < SPARES)) begin
                tbl_d.vld[cfg_idx] = cfg_vld;
                tbl_d.row[cfg_idx] = cfg_row;
            end
            if (cfg_lock)
                tbl_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            tbl_q <= '0;
        else
            tbl_q <= tbl_d;
    end

    assign ent_vld = tbl_q.vld;
    assign ent_row = tbl_q.row;

    // R5: outside the programming window the table never moves
    p_no_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> ($stable(tbl_q.vld) && $stable(tbl_q.row)));

    // R6: the lock is sticky
    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_q.lock |=> tbl_q.lock);

    // R6: a locked table is frozen
    p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_q.lock |=> ($stable(tbl_q.vld) && $stable(tbl_q.row)));
endmodule

// File: rtl/srm_remap.sv
module srm_remap #(
    parameter int SPARES   = 4,
    parameter int ROW_W    = 6,
    parameter int PHYS_W   = 7,
    parameter int LOG_ROWS = 64
) (
    input  logic [ROW_W-1:0]                addr,
    input  logic [SPARES-1:0]               ent_vld,
    input  logic [SPARES-1:0][ROW_W-1:0]    ent_row,
    output logic [SPARES-1:0]               win,
    output logic [PHYS_W-1:0]               phys_row
);
    logic [SPARES-1:0] match;

    for (genvar k = 0; k < SPARES; k++) begin : g_cmp
        assign match[k] = ent_vld[k] && (ent_row[k] == addr);
    end

    // isolate lowest-index match
    assign win = match & (~match + SPARES'(1));

    always_comb begin
        phys_row = PHYS_W'(addr);
        for (int k = 0; k < SPARES; k++) begin
            if (win[k])
                phys_row = PHYS_W'(LOG_ROWS + k);
        end
    end
endmodule

// File: rtl/srm_array.sv
module srm_array #(
    parameter int DATA_W    = 16,
    parameter int PHYS_ROWS = 68,
    parameter int PHYS_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  srm_pkg::acc_op_e  op,
    input  logic [PHYS_W-1:0] row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    import srm_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } rd_t;

    logic [DATA_W-1:0] mem_q [PHYS_ROWS];
    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.vld  = (op == OP_READ);
        rd_d.data = rd_q.data;
        if (op == OP_READ && int'(row) < PHYS_ROWS)
            rd_d.data = mem_q[row];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    always_ff @(posedge clk) begin
        if (op == OP_WRITE && int'(row) < PHYS_ROWS)
            mem_q[row] <= wdata;
    end

    assign rdata  = rd_q.data;
    assign rvalid = rd_q.vld;
endmodule

// File: rtl/spare_row_mem.sv
module spare_row_mem #(
    parameter int DATA_W   = 16,
    parameter int LOG_ROWS = 64,
    parameter int SPARES   = 4,
    localparam int ROW_W   = $clog2(LOG_ROWS),
    localparam int IDX_W   = (SPARES > 1) ? $clog2(SPARES) : 1,
    localparam int PHYS_ROWS = LOG_ROWS + SPARES,
    localparam int PHYS_W  = $clog2(PHYS_ROWS),
    localparam int DCNT_W  = $clog2(PHYS_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_prog_en,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_vld,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic              cfg_lock,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ROW_W-1:0]  acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [PHYS_W-1:0] acc_phys_row,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [DCNT_W-1:0] defect_cnt,
    output logic              unrepairable
);
    import srm_pkg::*;

    logic [SPARES-1:0]            ent_vld;
    logic [SPARES-1:0][ROW_W-1:0] ent_row;
    logic [SPARES-1:0]            spare_sel;
    logic [PHYS_W-1:0]            phys_row;
    acc_op_e                      op;

    assign op = decode_op(acc_en, acc_we);

    srm_repair_table #(.SPARES(SPARES), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .prog_en(cfg_prog_en), .cfg_wr(cfg_wr),
        .cfg_idx(cfg_idx), .cfg_vld(cfg_vld), .cfg_row(cfg_row),
        .cfg_lock(cfg_lock), .ent_vld(ent_vld), .ent_row(ent_row)
    );

    srm_remap #(.SPARES(SPARES), .ROW_W(ROW_W), .PHYS_W(PHYS_W),
                .LOG_ROWS(LOG_ROWS)) u_map (
        .addr(acc_addr), .ent_vld(ent_vld), .ent_row(ent_row),
        .win(spare_sel), .phys_row(phys_row)
    );

    srm_array #(.DATA_W(DATA_W), .PHYS_ROWS(PHYS_ROWS), .PHYS_W(PHYS_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .op(op), .row(phys_row),
        .wdata(acc_wdata), .rdata(rd_data), .rvalid(rd_valid)
    );

    assign acc_phys_row = phys_row;
    assign unrepairable = (int'(defect_cnt) > SPARES);

    // R4: a read yields valid data on the following cycle
    p_rd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we) |=> rd_valid);

    // R4: no read, no valid
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_we) |=> !rd_valid);

    // R3: a substituted access lands in the spare region
    p_spare_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|spare_sel) |-> (int'(phys_row) >= LOG_ROWS));

    // R7: at most one entry drives the substitution
    p_one_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spare_sel));
endmodule

// File: tb/spare_row_mem_tb_top.sv
module spare_row_mem_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int LOG_ROWS = 64;
    localparam int SPARES = 4;
    localparam int PHYS_ROWS = LOG_ROWS + SPARES;

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_prog_en = 0, cfg_wr = 0, cfg_vld = 0, cfg_lock = 0;
    logic [1:0] cfg_idx = 0;
    logic [5:0] cfg_row = 0;
    logic acc_en = 0, acc_we = 0;
    logic [5:0] acc_addr = 0;
    logic [DATA_W-1:0] acc_wdata = 0;
    logic [6:0] acc_phys_row;
    logic [DATA_W-1:0] rd_data;
    logic rd_valid;
    logic [6:0] defect_cnt = 0;
    logic unrepairable;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    bit m_vld [SPARES];
    int m_row [SPARES];
    bit m_lock;
    int m_mem [PHYS_ROWS];
    bit m_wr [PHYS_ROWS];

    always #(CLK_PERIOD/2) clk = ~clk;

    spare_row_mem dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_prog_en(cfg_prog_en), .cfg_wr(cfg_wr),
        .cfg_idx(cfg_idx), .cfg_vld(cfg_vld), .cfg_row(cfg_row),
        .cfg_lock(cfg_lock), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_phys_row(acc_phys_row),
        .rd_data(rd_data), .rd_valid(rd_valid), .defect_cnt(defect_cnt),
        .unrepairable(unrepairable)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_phys(input int a);
        for (int k = 0; k < SPARES; k++)
            if (m_vld[k] && m_row[k] == a)
                return LOG_ROWS + k;
        return a;
    endfunction

    task automatic cfg(input bit prog, input int idx, input bit v, input int row,
                       input bit lock);
        @(negedge clk);
        cfg_prog_en = prog; cfg_wr = 1; cfg_idx = 2'(idx); cfg_vld = v;
        cfg_row = 6'(row); cfg_lock = lock;
        @(posedge clk);
        if (prog && !m_lock) begin
            m_vld[idx] = v;
            m_row[idx] = row;
            if (lock) m_lock = 1;
        end
        #1;
        cfg_wr = 0; cfg_lock = 0; cfg_prog_en = 0;
    endtask

    task automatic acc(input bit we, input int a, input int data, input string tag);
        int ep;
        @(negedge clk);
        acc_en = 1; acc_we = we; acc_addr = 6'(a); acc_wdata = DATA_W'(data);
        #1;
        ep = ref_phys(a);
        chk(int'(acc_phys_row) == ep, {tag, " phys"}, int'(acc_phys_row), ep);
        @(posedge clk);
        #1;
        acc_en = 0;
        if (we) begin
            m_mem[ep] = data; m_wr[ep] = 1;
            chk(rd_valid == 0, "R4 no valid after write", int'(rd_valid), 0);
        end else begin
            chk(rd_valid == 1, "R4 valid after read", int'(rd_valid), 1);
            if (m_wr[ep])
                chk(int'(rd_data) == m_mem[ep], {tag, " data"}, int'(rd_data), m_mem[ep]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < SPARES; k++) begin m_vld[k] = 0; m_row[k] = 0; end
        for (int i = 0; i < PHYS_ROWS; i++) begin m_mem[i] = 0; m_wr[i] = 0; end
        m_lock = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(rd_valid == 0, "R1 rd_valid", int'(rd_valid), 0);
        chk(rd_data == 0, "R1 rd_data", int'(rd_data), 0);
        acc_addr = 6'd37; #1;
        chk(int'(acc_phys_row) == 37, "R1 empty table", int'(acc_phys_row), 37);

        // R2 identity mapping, R4 latency
        acc(1, 0, 16'h1111, "R2");
        acc(1, 5, 16'h5555, "R2");
        acc(1, 63, 16'hABCD, "R2");
        acc(0, 0, 0, "R2");
        acc(0, 63, 0, "R2");
        acc(0, 5, 0, "R4");

        // R5 write outside window ignored
        cfg(0, 0, 1, 5, 0);
        acc(0, 5, 0, "R5");

        // R3 substitution
        cfg(1, 0, 1, 5, 0);
        acc(1, 5, 16'h0F0F, "R3");
        acc(0, 5, 0, "R3");
        cfg(1, 2, 1, 10, 0);
        acc(1, 10, 16'h2222, "R3");
        acc(0, 10, 0, "R4");
        // R8 invalid entry
        cfg(1, 1, 0, 20, 0);
        acc(1, 20, 16'h3333, "R8");
        acc(0, 20, 0, "R8");
        // R7 duplicate in higher slot: slot 2 still wins
        cfg(1, 3, 1, 10, 0);
        acc(0, 10, 0, "R7");
        // duplicate in lower slot: slot 1 overtakes slot 2
        cfg(1, 1, 1, 10, 0);
        acc(1, 10, 16'h4444, "R7");
        acc(0, 10, 0, "R7");

        // R6 lock then attempts
        cfg(1, 1, 1, 10, 1);
        cfg(1, 0, 1, 30, 0);
        acc(0, 5, 0, "R6");
        acc(1, 30, 16'h7777, "R6");
        cfg(1, 1, 0, 10, 0);
        acc(0, 10, 0, "R6");
        acc(0, 30, 0, "R6");
        acc(0, 63, 0, "R2");

        // R9 unrepairable threshold
        @(negedge clk); defect_cnt = 0; #1;
        chk(unrepairable == 0, "R9 cnt0", int'(unrepairable), 0);
        defect_cnt = 4; #1;
        chk(unrepairable == 0, "R9 cnt4", int'(unrepairable), 0);
        defect_cnt = 5; #1;
        chk(unrepairable == 1, "R9 cnt5", int'(unrepairable), 1);
        defect_cnt = 68; #1;
        chk(unrepairable == 1, "R9 cnt68", int'(unrepairable), 1);

        @(negedge clk);
        chk(rd_valid == 0, "R4 idle", int'(rd_valid), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule